// File: doc/BRIEF.md
# Four-Lane Word Combiner with Elastic Rate Matching

This block rebuilds one word stream from four receive lanes when the far end places whole words on the lanes in rotation. Each lane writes into its own eight-entry elastic FIFO. One rotating read selector pulls at most one word per cycle from the lane it points at. A registered valid/data pair carries each word out, together with the number of the lane it came from.

The rates of the recovered clock and the local clock never match exactly, so the block adds or removes idle skip words. In striped mode it treats the four FIFOs as one pool. A central controller steers the shared selector to do this. It skips a lane to throw away a skip word when the pool is too full. It holds on a lane for one extra cycle to emit an extra skip word when the pool runs low. In trunking mode the four lanes are separate streams. The selector then moves forward one lane every cycle whatever happens, and each lane does its own rate matching against per-lane limits. A loopback control sends the combined output to the transmit-side port in place of the host's transmit word. Sticky overflow and underflow flags report FIFO faults until a clear pulse removes them.

Top module: `lane_combiner`

## Requirements
- R1: While reset is held and right after it ends, `out_vld` is 0, `err_ovf` and `err_unf` are all zeros, and with `lpbk_en` low the transmit port carries the host word.
- R2: In striped mode (`trunk_mode`=0) the selector reads lanes in the order 0,1,2,3,0,… and delivers at most one word per cycle on `out_vld`/`out_dat`/`out_k`. Words that are not skip words come out in the order they were striped and none is lost. A skip word is one with `k`=1 and data bits [7:0] equal to 8'hF7.
- R3: In striped mode, suppose the word at the head of the selected lane is a skip word and the four FIFOs together hold more than `HI_WM` (16) words. The skip word is then removed without being output, and the selector moves on to the next lane.
- R4: In striped mode, suppose the last word delivered from a FIFO was a skip word and the FIFOs together hold fewer than `LO_WM` (8) words. One extra skip word (k=1, data 16'h00F7) is then output. The selector stays on the same lane, so that lane supplies the next word as well.
- R5: In trunking mode (`trunk_mode`=1) the selector moves forward exactly one lane every cycle. An empty lane never holds up the others, and each lane's words come out in order, tagged on `out_lane` with that lane's number.
- R6: In trunking mode, a skip word at the head of a lane is removed without output when that lane holds more than `HI_WM/4` (4) words.
- R7: In trunking mode, once a lane has delivered a skip word, one extra skip word is output for that lane on its next turn if that lane then holds fewer than `LO_WM/4` (2) words.
- R8: A word written to a lane whose FIFO holds 8 words, with no read from that lane in the same cycle, is dropped. The lane's bit in `err_ovf` is then set and stays set.
- R9: In striped mode, if the selected lane is empty while another lane holds data, no word is output and that lane's bit in `err_unf` is set and stays set.
- R10: A one-cycle pulse on `err_clr` clears all `err_ovf` and `err_unf` bits. A fault that occurs in the same cycle wins over the clear.
- R11: With `lpbk_en` high, `tx_vld`/`tx_dat`/`tx_k` follow `out_vld`/`out_dat`/`out_k` in every cycle. With it low they follow the host transmit inputs.

Changing `trunk_mode` is only allowed while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trunk_mode | input | 1 | 0 = striped stream, 1 = four independent streams |
| lane_vld | input | 4 | Per-lane write strobe |
| lane_dat | input | 4*DW | Per-lane word; lane i at bits [i*DW +: DW] |
| lane_k | input | 4 | Per-lane control flag |
| err_clr | input | 1 | Clears the sticky error flags |
| lpbk_en | input | 1 | Routes the combined output to the transmit port |
| host_tx_vld | input | 1 | Host transmit valid |
| host_tx_dat | input | DW | Host transmit word |
| host_tx_k | input | 1 | Host transmit control flag |
| out_vld | output | 1 | Combined output valid |
| out_dat | output | DW | Combined output word |
| out_k | output | 1 | Combined output control flag |
| out_lane | output | 2 | Lane the output word was read from |
| tx_vld | output | 1 | Transmit-side valid |
| tx_dat | output | DW | Transmit-side word |
| tx_k | output | 1 | Transmit-side control flag |
| err_ovf | output | 4 | Sticky per-lane overflow flags |
| err_unf | output | 4 | Sticky per-lane underflow flags |

## Verification
The bench runs a steady striped stream with no skip words, fed in two bursts. Any change to the order, any lost word or any false stall is caught by an exact comparison of the sequence. A striped stream with one skip word early, while the pool is full, and one late, while it is nearly empty, tells deletion and insertion apart: the expected output lacks the first skip, doubles the second, and shows the dwell in the lane tags. In trunking mode, two sparse lanes show that an empty lane does not stall the rotation, which would not be true in striped mode. One lane filled in a burst and one lane fed a lone skip show the per-lane delete and insert limits. Writing to a single lane with lane 0 empty produces both faults at once, so their flags, how long they stay set, and the clear can be checked.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LANES = 4;
  localparam int SW    = $clog2(LANES);

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_DROP,
    ACT_FILL,
    ACT_PASS
  } act_e;
endpackage

// File: rtl/lc_lane_fifo.sv
module lc_lane_fifo #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_dat,
  input  logic          push_k,
  input  logic          pop,
  output logic [DW-1:0] head_dat,
  output logic          head_k,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, wr_ok;

  always_comb begin
    full  = (cnt_q == CW'(DEPTH));
    wr_ok = push && (!full || pop);
    ovf   = push && full && !pop;
    wp_d  = wr_ok ? AW'(wp_q + 1'b1) : wp_q;
    rp_d  = pop ? AW'(rp_q + 1'b1) : rp_q;
    cnt_d = cnt_q;
    if (wr_ok && !pop) cnt_d = cnt_q + 1'b1;
    else if (!wr_ok && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= {push_k, push_dat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  assign {head_k, head_dat} = mem[rp_q];
  assign count              = cnt_q;

  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/lc_read_ctrl.sv
module lc_read_ctrl
  import lc_pkg::*;
#(
  parameter  int         DW       = 16,
  parameter  int         DEPTH    = 8,
  parameter  int         HI_WM    = 16,
  parameter  int         LO_WM    = 8,
  parameter  int         LANE_HI  = 4,
  parameter  int         LANE_LO  = 2,
  parameter  logic [7:0] SKIP_PAT = 8'hF7,
  localparam int         CW       = $clog2(DEPTH + 1),
  localparam int         TW       = $clog2(LANES * DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trunk_mode,
  input  logic [LANES-1:0][CW-1:0]  lane_cnt,
  input  logic [LANES-1:0][DW-1:0]  head_dat,
  input  logic [LANES-1:0]          head_k,
  output logic [LANES-1:0]          pop,
  output logic [LANES-1:0]          unf,
  output logic                      out_vld,
  output logic [DW-1:0]             out_dat,
  output logic                      out_k,
  output logic [SW-1:0]             out_lane
);
  logic [SW-1:0]    sel_q, sel_d;
  logic             gskip_q, gskip_d;
  logic [LANES-1:0] lskip_q, lskip_d;
  logic [TW-1:0]    total;
  logic [CW-1:0]    sel_cnt;
  logic             sel_empty, h_skip, skip_flag;
  act_e             act;
  logic             vld_d, k_d;
  logic [DW-1:0]    dat_d;

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) total = total + TW'(lane_cnt[i]);
    sel_cnt   = lane_cnt[sel_q];
    sel_empty = (sel_cnt == '0);
    h_skip    = head_k[sel_q] && (head_dat[sel_q][7:0] == SKIP_PAT);
    skip_flag = trunk_mode ? lskip_q[sel_q] : gskip_q;
    act       = ACT_IDLE;
    unf       = '0;
    if (trunk_mode) begin
      if (!sel_empty && h_skip && sel_cnt > CW'(LANE_HI)) act = ACT_DROP;
      else if (skip_flag && sel_cnt < CW'(LANE_LO))       act = ACT_FILL;
      else if (!sel_empty)                                act = ACT_PASS;
    end else begin
      if (!sel_empty && h_skip && total > TW'(HI_WM))     act = ACT_DROP;
      else if (skip_flag && total < TW'(LO_WM))           act = ACT_FILL;
      else if (!sel_empty)                                act = ACT_PASS;
      else unf[sel_q] = (total != '0);
    end
  end

  always_comb begin
    pop     = '0;
    sel_d   = sel_q;
    gskip_d = gskip_q;
    lskip_d = lskip_q;
    vld_d   = 1'b0;
    k_d     = 1'b0;
    dat_d   = '0;
    if (trunk_mode || act == ACT_DROP || act == ACT_PASS) sel_d = sel_q + 1'b1;
    case (act)
      ACT_DROP: pop[sel_q] = 1'b1;
      ACT_FILL: begin
        vld_d = 1'b1;
        k_d   = 1'b1;
        dat_d = DW'(SKIP_PAT);
        if (trunk_mode) lskip_d[sel_q] = 1'b0;
        else            gskip_d        = 1'b0;
      end
      ACT_PASS: begin
        pop[sel_q] = 1'b1;
        vld_d      = 1'b1;
        k_d        = head_k[sel_q];
        dat_d      = head_dat[sel_q];
        if (trunk_mode) lskip_d[sel_q] = h_skip;
        else            gskip_d        = h_skip;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      gskip_q  <= 1'b0;
      lskip_q  <= '0;
      out_vld  <= 1'b0;
      out_dat  <= '0;
      out_k    <= 1'b0;
      out_lane <= '0;
    end else begin
      sel_q    <= sel_d;
      gskip_q  <= gskip_d;
      lskip_q  <= lskip_d;
      out_vld  <= vld_d;
      out_dat  <= dat_d;
      out_k    <= k_d;
      out_lane <= sel_q;
    end
  end

  assert_single_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));
  assert_trunk_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trunk_mode |=> (sel_q == $past(sel_q) + 1'b1));
  assert_unf_striped_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|unf) |-> (!trunk_mode && !out_vld_next_idle_chk(vld_d)));

  function automatic logic out_vld_next_idle_chk(input logic v);
    return v;
  endfunction
endmodule

// File: rtl/lane_combiner.sv
module lane_combiner
  import lc_pkg::*;
#(
  parameter  int         DW       = 16,
  parameter  int         DEPTH    = 8,
  parameter  int         HI_WM    = 16,
  parameter  int         LO_WM    = 8,
  parameter  logic [7:0] SKIP_PAT = 8'hF7,
  localparam int         CW       = $clog2(DEPTH + 1),
  localparam int         LANE_HI  = HI_WM / LANES,
  localparam int         LANE_LO  = LO_WM / LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trunk_mode,
  input  logic [LANES-1:0]      lane_vld,
  input  logic [LANES*DW-1:0]   lane_dat,
  input  logic [LANES-1:0]      lane_k,
  input  logic                  err_clr,
  input  logic                  lpbk_en,
  input  logic                  host_tx_vld,
  input  logic [DW-1:0]         host_tx_dat,
  input  logic                  host_tx_k,
  output logic                  out_vld,
  output logic [DW-1:0]         out_dat,
  output logic                  out_k,
  output logic [SW-1:0]         out_lane,
  output logic                  tx_vld,
  output logic [DW-1:0]         tx_dat,
  output logic                  tx_k,
  output logic [LANES-1:0]      err_ovf,
  output logic [LANES-1:0]      err_unf
);
  logic [LANES-1:0][CW-1:0] cnt;
  logic [LANES-1:0][DW-1:0] hdat;
  logic [LANES-1:0]         hk, pop, ovf_p, unf_p;
  logic [LANES-1:0]         ovf_q, ovf_d, unf_q, unf_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lc_lane_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (lane_vld[g]),
      .push_dat (lane_dat[g*DW +: DW]),
      .push_k   (lane_k[g]),
      .pop      (pop[g]),
      .head_dat (hdat[g]),
      .head_k   (hk[g]),
      .count    (cnt[g]),
      .ovf      (ovf_p[g])
    );

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[g] && !err_clr) |=> ovf_q[g]);
    assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_q[g] && !err_clr) |=> unf_q[g]);
  end

  lc_read_ctrl #(
    .DW(DW), .DEPTH(DEPTH), .HI_WM(HI_WM), .LO_WM(LO_WM),
    .LANE_HI(LANE_HI), .LANE_LO(LANE_LO), .SKIP_PAT(SKIP_PAT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trunk_mode (trunk_mode),
    .lane_cnt   (cnt),
    .head_dat   (hdat),
    .head_k     (hk),
    .pop        (pop),
    .unf        (unf_p),
    .out_vld    (out_vld),
    .out_dat    (out_dat),
    .out_k      (out_k),
    .out_lane   (out_lane)
  );

  always_comb begin
    ovf_d = (err_clr ? '0 : ovf_q) | ovf_p;
    unf_d = (err_clr ? '0 : unf_q) | unf_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      unf_q <= '0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign err_ovf = ovf_q;
  assign err_unf = unf_q;
  assign tx_vld  = lpbk_en ? out_vld : host_tx_vld;
  assign tx_dat  = lpbk_en ? out_dat : host_tx_dat;
  assign tx_k    = lpbk_en ? out_k   : host_tx_k;

  assert_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(|ovf_p)) |=> (err_ovf == '0));
endmodule

// File: tb/lane_combiner_test.sv
module lane_combiner_test;
  localparam int DW = 16;

  logic          clk, rst_n, trunk_mode, err_clr, lpbk_en;
  logic [3:0]    lane_vld, lane_k;
  logic [4*DW-1:0] lane_dat;
  logic          host_tx_vld, host_tx_k;
  logic [DW-1:0] host_tx_dat;
  logic          out_vld, out_k, tx_vld, tx_k;
  logic [DW-1:0] out_dat, tx_dat;
  logic [1:0]    out_lane;
  logic [3:0]    err_ovf, err_unf;

  int n_chk, n_err, lb_mis;
  bit done;
  logic [16:0] got_q[$];
  logic [1:0]  got_l[$];
  logic [16:0] exp_q[$];

  lane_combiner uut (
    .clk(clk), .rst_n(rst_n), .trunk_mode(trunk_mode), .lane_vld(lane_vld),
    .lane_dat(lane_dat), .lane_k(lane_k), .err_clr(err_clr), .lpbk_en(lpbk_en),
    .host_tx_vld(host_tx_vld), .host_tx_dat(host_tx_dat), .host_tx_k(host_tx_k),
    .out_vld(out_vld), .out_dat(out_dat), .out_k(out_k), .out_lane(out_lane),
    .tx_vld(tx_vld), .tx_dat(tx_dat), .tx_k(tx_k),
    .err_ovf(err_ovf), .err_unf(err_unf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      got_q.push_back({out_k, out_dat});
      got_l.push_back(out_lane);
    end
    if (rst_n && lpbk_en &&
        ({tx_vld, tx_k, tx_dat} != {out_vld, out_k, out_dat})) lb_mis++;
  end

  function automatic logic [16:0] wd(input int n);
    return {1'b0, 16'h0100 + 16'(n)};
  endfunction

  localparam logic [16:0] SKW = {1'b1, 16'h00F7};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; trunk_mode = mode; lane_vld = '0; lane_k = '0; lane_dat = '0;
    err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    got_q.delete(); got_l.delete(); exp_q.delete();
  endtask

  task automatic drive(input logic [3:0] v, input logic [16:0] w0, input logic [16:0] w1,
                       input logic [16:0] w2, input logic [16:0] w3);
    @(negedge clk);
    lane_vld = v;
    lane_k   = {w3[16], w2[16], w1[16], w0[16]};
    lane_dat = {w3[15:0], w2[15:0], w1[15:0], w0[15:0]};
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    lane_vld = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp_all(input string req);
    chk(req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) chk(req, got_q[i], exp_q[i]);
  endtask

  task automatic cmp_lane(input string req, input logic [1:0] ln);
    int j = 0;
    for (int i = 0; i < got_q.size(); i++) begin
      if (got_l[i] == ln) begin
        if (j < exp_q.size()) chk(req, got_q[i], exp_q[j]);
        j++;
      end
    end
    chk(req, j, exp_q.size());
  endtask

  initial begin
    n_chk = 0; n_err = 0; lb_mis = 0; done = 0;
    lpbk_en = 1'b0; host_tx_vld = 1'b1; host_tx_dat = 16'h5A5A; host_tx_k = 1'b0;
    do_reset(1'b0);
    // R1 reset state
    chk("R1 out_vld", out_vld, 0);
    chk("R1 err_ovf", err_ovf, 0);
    chk("R1 err_unf", err_unf, 0);
    // R11 host passthrough
    chk("R11 host tx_dat", tx_dat, 16'h5A5A);
    chk("R11 host tx_vld", tx_vld, 1);

    // R2 striped order, two bursts, loopback on
    lpbk_en = 1'b1;
    for (int b = 0; b < 2; b++) begin
      for (int g = 0; g < 6; g++) begin
        int n = b * 24 + g * 4;
        drive(4'hF, wd(n), wd(n+1), wd(n+2), wd(n+3));
        for (int k = 0; k < 4; k++) exp_q.push_back(wd(n + k));
      end
      idle(40);
    end
    cmp_all("R2 striped order");
    chk("R2 no false underflow", err_unf, 0);
    chk("R11 loopback mismatches", lb_mis, 0);
    lpbk_en = 1'b0;

    // R3 delete at high fill, R4 insert at low fill
    do_reset(1'b0);
    for (int g = 0; g < 6; g++) begin
      logic [16:0] w [4];
      for (int k = 0; k < 4; k++) w[k] = (g*4+k == 5 || g*4+k == 20) ? SKW : wd(g*4+k);
      drive(4'hF, w[0], w[1], w[2], w[3]);
    end
    idle(40);
    for (int n = 0; n < 24; n++) begin
      if (n == 5) continue;
      exp_q.push_back(n == 20 ? SKW : wd(n));
      if (n == 20) exp_q.push_back(SKW);
    end
    cmp_all("R3 R4 skip delete/insert");
    if (got_l.size() >= 22) begin
      chk("R4 dwell lane of inserted skip", got_l[20], 1);
      chk("R4 dwell lane of next word", got_l[21], 1);
      chk("R3 lane passed over", got_l[5], 2);
    end

    // R5 trunking: sparse lanes 0 and 2 do not stall
    do_reset(1'b1);
    for (int i = 0; i < 3; i++) drive(4'b0101, wd(i), 17'd0, wd(16+i), 17'd0);
    idle(30);
    chk("R5 total words", got_q.size(), 6);
    for (int i = 0; i < 3; i++) exp_q.push_back(wd(i));
    cmp_lane("R5 lane0 stream", 2'd0);
    exp_q.delete();
    for (int i = 0; i < 3; i++) exp_q.push_back(wd(16+i));
    cmp_lane("R5 lane2 stream", 2'd2);

    // R6 trunking per-lane delete
    do_reset(1'b1);
    for (int i = 0; i < 8; i++) drive(4'b0100, 17'd0, 17'd0, (i == 2) ? SKW : wd(i), 17'd0);
    idle(50);
    for (int i = 0; i < 8; i++) if (i != 2) exp_q.push_back(wd(i));
    cmp_lane("R6 lane delete", 2'd2);

    // R7 trunking per-lane insert
    do_reset(1'b1);
    drive(4'b0001, SKW, 17'd0, 17'd0, 17'd0);
    drive(4'b0001, wd(7), 17'd0, 17'd0, 17'd0);
    idle(30);
    exp_q.push_back(SKW); exp_q.push_back(SKW); exp_q.push_back(wd(7));
    cmp_lane("R7 lane insert", 2'd0);

    // R8 overflow, R9 underflow, R10 clear
    do_reset(1'b0);
    for (int i = 0; i < 9; i++) drive(4'b1000, 17'd0, 17'd0, 17'd0, wd(64+i));
    idle(2);
    chk("R8 overflow flag", err_ovf, 4'b1000);
    chk("R9 underflow flag", err_unf, 4'b0001);
    chk("R9 no output while stalled", got_q.size(), 0);
    for (int i = 0; i < 8; i++) drive(4'b0111, wd(i), wd(16+i), wd(32+i), 17'd0);
    idle(60);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(wd(i)); exp_q.push_back(wd(16+i));
      exp_q.push_back(wd(32+i)); exp_q.push_back(wd(64+i));
    end
    cmp_all("R8 ninth word dropped");
    chk("R8 overflow sticky", err_ovf, 4'b1000);
    chk("R9 underflow sticky", err_unf, 4'b0001);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R10 ovf cleared", err_ovf, 0);
    chk("R10 unf cleared", err_unf, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule